// File: doc/BRIEF.md
# Integer Issue Queue with Class Steering

This block is the scheduling window in front of two integer ALUs. It holds up to sixteen decoded integer operations and accepts up to four new ones per clock from a dispatch port. Each entry keeps three physical source-register numbers, and each source has its own ready flag. Each flag starts from the busy state supplied at dispatch. After that it is set when any of three result-tag broadcasts names that register.

Every clock the queue picks up to two entries whose three sources are all ready. The oldest eligible entry goes first, and the pick is steered by the operation's class:
- the first ALU alone accepts branches and shifts;
- the second ALU alone accepts multiply and divide;
- any other operation may use whichever ALU is left free.

An issued entry is released at once and does not wait for the result. Every entry carries a branch-dependency mask. A mispredicted branch removes every entry whose mask contains that branch's bit. A correctly resolved branch clears its bit from every mask. Register-file reads and the ALUs themselves sit outside this block.

Top module: `int_issue_queue`

## Requirements
- R1: A synchronous active-high reset empties every entry. While reset is held and after it is released, both issue-valid outputs are 0 and `full_o` is 0.
- R2: Dispatch lanes are written only while `full_o` is 0. `full_o` is 1 exactly when fewer than four entries are free. Lanes presented while `full_o` is 1 are dropped.
- R3: Class codes are 2'b01 for branch or shift, which issue only on port 0, and 2'b10 for multiply or divide, which issue only on port 1. The codes 2'b00 and 2'b11 may issue on either port.
- R4: An entry issues only when all three of its source ready flags are set. If an entry is eligible during the cycle after edge k, it appears on an issue port at edge k+1. It is freed by that issue and never issues twice.
- R5: At dispatch, each source's ready flag is the lane's ready input ORed with a match against the write-back tags valid in that same cycle.
- R6: A valid write-back tag on any of the three ports sets the ready flag of every held source that carries that register number.
- R7: Among eligible entries competing for the same port, the one dispatched earliest wins. Within one dispatch group, a lower lane counts as older.
- R8: An either-class entry takes port 0 when no branch or shift entry claims it. Otherwise it takes port 1 when no multiply or divide entry claims that port. Two entries can issue in one cycle.
- R9: An issue port carries the entry's function code, immediate, destination register and the three source register numbers. Source s sits at bits [6s+5:6s] of the port's 18-bit source field.
- R10: When `mp_valid_i` is 1, every held entry whose mask ANDed with `mp_mask_i` is nonzero is removed and never issues. A lane dispatched in that same cycle with an overlapping mask is dropped.
- R11: When `res_valid_i` is 1, the bits of `res_mask_i` are cleared from every held mask. A later mispredict on that bit then leaves those entries in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_valid_i | input | 4 | Per-lane dispatch valid |
| disp_cls_i | input | 8 | Per-lane class, 2 bits per lane |
| disp_func_i | input | 24 | Per-lane function code, 6 bits per lane |
| disp_imm_i | input | 64 | Per-lane immediate, 16 bits per lane |
| disp_dst_i | input | 24 | Per-lane destination register, 6 bits per lane |
| disp_src_i | input | 72 | Per-lane three source registers, 18 bits per lane |
| disp_srdy_i | input | 12 | Per-lane source ready flags, 3 per lane |
| disp_bmask_i | input | 16 | Per-lane branch mask, 4 bits per lane |
| wb_valid_i | input | 3 | Write-back tag valid per port |
| wb_tag_i | input | 18 | Write-back register numbers, 6 bits per port |
| mp_valid_i | input | 1 | Mispredict strobe |
| mp_mask_i | input | 4 | Mispredicted branch bit |
| res_valid_i | input | 1 | Correct-resolve strobe |
| res_mask_i | input | 4 | Resolved branch bit |
| full_o | output | 1 | Fewer than four free entries |
| iss_valid_o | output | 2 | Issue valid, bit 0 for port 0, bit 1 for port 1 |
| iss_func_o | output | 12 | Issued function codes |
| iss_imm_o | output | 32 | Issued immediates |
| iss_dst_o | output | 12 | Issued destination registers |
| iss_src_o | output | 36 | Issued source registers, 18 bits per port |

## Verification
An instruction that is ready at dispatch appears on an issue port one edge after the edge that writes it. A write-back tag likewise releases its consumer one edge after the edge that samples it. Flushes and resolves act on the edge that samples them, and `full_o` follows the entry count on the edge that changes it. The bench drives each stimulus just after a falling edge, so a dispatch or wake-up result is read two falling edges later. The following falling edge then confirms that the port has gone quiet.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int IQ_NSRC = 3;

  typedef enum logic [1:0] {
    CLS_ANY = 2'b00,
    CLS_A1  = 2'b01,
    CLS_A2  = 2'b10,
    CLS_RSV = 2'b11
  } iq_cls_e;
endpackage

// File: rtl/iq_free_alloc.sv
module iq_free_alloc #(
  parameter int N     = 16,
  parameter int LANES = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]           vld_i,
  output logic [LANES*IDX_W-1:0] slot_o,
  output logic                   room_o
);
  int cnt;

  // lane d receives the d-th free entry, counted from index 0 upward
  always_comb begin
    slot_o = '0;
    cnt    = 0;
    for (int i = 0; i < N; i++) begin
      if (!vld_i[i]) begin
        if (cnt < LANES) slot_o[cnt*IDX_W +: IDX_W] = IDX_W'(i);
        cnt = cnt + 1;
      end
    end
    room_o = (cnt >= LANES);
  end
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
  parameter int N     = 16,
  parameter int AGE_W = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       req_i,
  input  logic [N*AGE_W-1:0] age_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [AGE_W-1:0] best;

  // strictly-greater compare in ascending order: ties go to the lower index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!found_o || age_i[i*AGE_W +: AGE_W] > best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = age_i[i*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/int_issue_queue.sv
module int_issue_queue
  import iq_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int LANES    = 4,
  parameter int WB_PORTS = 3,
  parameter int PREG_W   = 6,
  parameter int BR_W     = 4,
  parameter int FUNC_W   = 6,
  parameter int IMM_W    = 16,
  parameter int AGE_W    = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [LANES-1:0]                 disp_valid_i,
  input  logic [LANES*2-1:0]               disp_cls_i,
  input  logic [LANES*FUNC_W-1:0]          disp_func_i,
  input  logic [LANES*IMM_W-1:0]           disp_imm_i,
  input  logic [LANES*PREG_W-1:0]          disp_dst_i,
  input  logic [LANES*IQ_NSRC*PREG_W-1:0]  disp_src_i,
  input  logic [LANES*IQ_NSRC-1:0]         disp_srdy_i,
  input  logic [LANES*BR_W-1:0]            disp_bmask_i,
  input  logic [WB_PORTS-1:0]              wb_valid_i,
  input  logic [WB_PORTS*PREG_W-1:0]       wb_tag_i,
  input  logic                             mp_valid_i,
  input  logic [BR_W-1:0]                  mp_mask_i,
  input  logic                             res_valid_i,
  input  logic [BR_W-1:0]                  res_mask_i,
  output logic                             full_o,
  output logic [1:0]                       iss_valid_o,
  output logic [2*FUNC_W-1:0]              iss_func_o,
  output logic [2*IMM_W-1:0]               iss_imm_o,
  output logic [2*PREG_W-1:0]              iss_dst_o,
  output logic [2*IQ_NSRC*PREG_W-1:0]      iss_src_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NSRC  = IQ_NSRC;
  localparam int SRC_W = NSRC * PREG_W;
  localparam int NALU  = 2;

  // entry storage
  logic [ENTRIES-1:0] vld_q;
  iq_cls_e            cls_q  [ENTRIES];
  logic [FUNC_W-1:0]  func_q [ENTRIES];
  logic [IMM_W-1:0]   imm_q  [ENTRIES];
  logic [PREG_W-1:0]  dst_q  [ENTRIES];
  logic [SRC_W-1:0]   src_q  [ENTRIES];
  logic [NSRC-1:0]    rdy_q  [ENTRIES];
  logic [BR_W-1:0]    bm_q   [ENTRIES];
  logic [AGE_W-1:0]   age_q  [ENTRIES];

  // issue registers
  logic [NALU-1:0]    iss_v_q;
  iq_cls_e            iss_cls_q  [NALU];
  logic [IDX_W-1:0]   iss_idx_q  [NALU];
  logic [FUNC_W-1:0]  iss_func_q [NALU];
  logic [IMM_W-1:0]   iss_imm_q  [NALU];
  logic [PREG_W-1:0]  iss_dst_q  [NALU];
  logic [SRC_W-1:0]   iss_src_q  [NALU];

  function automatic logic tag_hit(input logic [PREG_W-1:0] t,
                                   input logic [WB_PORTS-1:0] v,
                                   input logic [WB_PORTS*PREG_W-1:0] tags);
    logic h;
    h = 1'b0;
    for (int p = 0; p < WB_PORTS; p++)
      if (v[p] && tags[p*PREG_W +: PREG_W] == t) h = 1'b1;
    return h;
  endfunction

  logic [BR_W-1:0] res_m;
  assign res_m = res_valid_i ? res_mask_i : '0;

  // dispatch lanes and slot allocation
  logic [LANES*IDX_W-1:0] slot_flat;
  logic                   room;
  logic [IDX_W-1:0]       slot   [LANES];
  logic [LANES-1:0]       lane_ok;

  iq_free_alloc #(.N(ENTRIES), .LANES(LANES), .IDX_W(IDX_W)) u_alloc (
    .vld_i (vld_q),
    .slot_o(slot_flat),
    .room_o(room)
  );
  assign full_o = ~room;

  for (genvar d = 0; d < LANES; d++) begin : g_lane
    assign slot[d]    = slot_flat[d*IDX_W +: IDX_W];
    assign lane_ok[d] = room & disp_valid_i[d]
                      & ~(mp_valid_i & |(disp_bmask_i[d*BR_W +: BR_W] & mp_mask_i));
  end

  // eligibility per entry, split by class
  logic [ENTRIES-1:0]       kill, elig, req_a1, req_a2, req_any, req_any2, take;
  logic [ENTRIES*AGE_W-1:0] age_flat;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign kill[i]    = vld_q[i] & mp_valid_i & |(bm_q[i] & mp_mask_i);
    assign elig[i]    = vld_q[i] & (&rdy_q[i]) & ~kill[i];
    assign req_a1[i]  = elig[i] & (cls_q[i] == CLS_A1);
    assign req_a2[i]  = elig[i] & (cls_q[i] == CLS_A2);
    assign req_any[i] = elig[i] & ((cls_q[i] == CLS_ANY) | (cls_q[i] == CLS_RSV));
    assign age_flat[i*AGE_W +: AGE_W] = age_q[i];
  end

  logic             p1_f, p2_f, pa_f, pb_f;
  logic [IDX_W-1:0] p1_i, p2_i, pa_i, pb_i;

  iq_oldest_pick #(.N(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_a1 (
    .req_i(req_a1), .age_i(age_flat), .found_o(p1_f), .idx_o(p1_i));
  iq_oldest_pick #(.N(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_a2 (
    .req_i(req_a2), .age_i(age_flat), .found_o(p2_f), .idx_o(p2_i));
  iq_oldest_pick #(.N(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_any (
    .req_i(req_any), .age_i(age_flat), .found_o(pa_f), .idx_o(pa_i));

  always_comb begin
    req_any2 = req_any;
    if (pa_f) req_any2[pa_i] = 1'b0;
  end

  iq_oldest_pick #(.N(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_any2 (
    .req_i(req_any2), .age_i(age_flat), .found_o(pb_f), .idx_o(pb_i));

  // port steering: dedicated classes first, either-class fills the gaps
  logic [NALU-1:0]  sel_v;
  logic [IDX_W-1:0] sel_i [NALU];

  always_comb begin
    sel_v[0] = p1_f | pa_f;
    sel_i[0] = p1_f ? p1_i : pa_i;
    if (p2_f) begin
      sel_v[1] = 1'b1;  sel_i[1] = p2_i;
    end else if (p1_f) begin
      sel_v[1] = pa_f;  sel_i[1] = pa_i;
    end else begin
      sel_v[1] = pb_f;  sel_i[1] = pb_i;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_take
    assign take[i] = (sel_v[0] && sel_i[0] == IDX_W'(i))
                   | (sel_v[1] && sel_i[1] == IDX_W'(i));
  end

  // occupancy and issue-valid state
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      iss_v_q <= '0;
    end else begin
      iss_v_q <= sel_v;
      for (int i = 0; i < ENTRIES; i++)
        if (kill[i] | take[i]) vld_q[i] <= 1'b0;
      for (int d = 0; d < LANES; d++)
        if (lane_ok[d]) vld_q[slot[d]] <= 1'b1;
    end
  end

  // payload, wake-up, mask and age state
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i]) begin
        if (age_q[i] != '1) age_q[i] <= age_q[i] + 1'b1;
        bm_q[i] <= bm_q[i] & ~res_m;
        for (int s = 0; s < NSRC; s++)
          if (tag_hit(src_q[i][s*PREG_W +: PREG_W], wb_valid_i, wb_tag_i))
            rdy_q[i][s] <= 1'b1;
      end
    end
    for (int d = 0; d < LANES; d++) begin
      if (lane_ok[d]) begin
        cls_q[slot[d]]  <= iq_cls_e'(disp_cls_i[d*2 +: 2]);
        func_q[slot[d]] <= disp_func_i[d*FUNC_W +: FUNC_W];
        imm_q[slot[d]]  <= disp_imm_i[d*IMM_W +: IMM_W];
        dst_q[slot[d]]  <= disp_dst_i[d*PREG_W +: PREG_W];
        src_q[slot[d]]  <= disp_src_i[d*SRC_W +: SRC_W];
        bm_q[slot[d]]   <= disp_bmask_i[d*BR_W +: BR_W] & ~res_m;
        age_q[slot[d]]  <= '0;
        for (int s = 0; s < NSRC; s++)
          rdy_q[slot[d]][s] <= disp_srdy_i[d*NSRC + s]
                             | tag_hit(disp_src_i[d*SRC_W + s*PREG_W +: PREG_W],
                                       wb_valid_i, wb_tag_i);
      end
    end
    for (int k = 0; k < NALU; k++) begin
      iss_idx_q[k]  <= sel_i[k];
      iss_cls_q[k]  <= cls_q[sel_i[k]];
      iss_func_q[k] <= func_q[sel_i[k]];
      iss_imm_q[k]  <= imm_q[sel_i[k]];
      iss_dst_q[k]  <= dst_q[sel_i[k]];
      iss_src_q[k]  <= src_q[sel_i[k]];
    end
  end

  assign iss_valid_o = iss_v_q;
  for (genvar k = 0; k < NALU; k++) begin : g_out
    assign iss_func_o[k*FUNC_W +: FUNC_W] = iss_func_q[k];
    assign iss_imm_o[k*IMM_W +: IMM_W]    = iss_imm_q[k];
    assign iss_dst_o[k*PREG_W +: PREG_W]  = iss_dst_q[k];
    assign iss_src_o[k*SRC_W +: SRC_W]    = iss_src_q[k];
  end

  // checks on the selection and occupancy logic
  a_r3_port0_class: assert property (@(posedge clk) disable iff (rst)
    iss_v_q[0] |-> iss_cls_q[0] != CLS_A2);
  a_r3_port1_class: assert property (@(posedge clk) disable iff (rst)
    iss_v_q[1] |-> iss_cls_q[1] != CLS_A1);
  a_r4_freed_on_issue: assert property (@(posedge clk) disable iff (rst)
    iss_v_q[0] |-> !vld_q[iss_idx_q[0]]);
  a_r8_distinct_pick: assert property (@(posedge clk) disable iff (rst)
    (&iss_v_q) |-> iss_idx_q[0] != iss_idx_q[1]);
  a_r2_full_no_growth: assert property (@(posedge clk) disable iff (rst)
    full_o |=> $countones(vld_q) <= $past($countones(vld_q)));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    a_r10_flush_drops: assert property (@(posedge clk) disable iff (rst)
      (vld_q[i] && mp_valid_i && |(bm_q[i] & mp_mask_i)) |=> !vld_q[i]);
  end
endmodule

// File: tb/int_issue_queue_tb.sv
`timescale 1ns/1ps
module int_issue_queue_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  disp_valid;
  logic [7:0]  disp_cls;
  logic [23:0] disp_func;
  logic [63:0] disp_imm;
  logic [23:0] disp_dst;
  logic [71:0] disp_src;
  logic [11:0] disp_srdy;
  logic [15:0] disp_bmask;
  logic [2:0]  wb_valid;
  logic [17:0] wb_tag;
  logic        mp_valid, res_valid;
  logic [3:0]  mp_mask, res_mask;
  logic        full;
  logic [1:0]  iss_valid;
  logic [11:0] iss_func;
  logic [31:0] iss_imm;
  logic [11:0] iss_dst;
  logic [35:0] iss_src;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  int_issue_queue u_dut (
    .clk(clk), .rst(rst),
    .disp_valid_i(disp_valid), .disp_cls_i(disp_cls), .disp_func_i(disp_func),
    .disp_imm_i(disp_imm), .disp_dst_i(disp_dst), .disp_src_i(disp_src),
    .disp_srdy_i(disp_srdy), .disp_bmask_i(disp_bmask),
    .wb_valid_i(wb_valid), .wb_tag_i(wb_tag),
    .mp_valid_i(mp_valid), .mp_mask_i(mp_mask),
    .res_valid_i(res_valid), .res_mask_i(res_mask),
    .full_o(full), .iss_valid_o(iss_valid), .iss_func_o(iss_func),
    .iss_imm_o(iss_imm), .iss_dst_o(iss_dst), .iss_src_o(iss_src)
  );

  typedef struct packed {
    logic [1:0] cls;
    logic [5:0] func;
    logic [1:0] exp_v;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{cls: 2'b01, func: 6'd1, exp_v: 2'b01},
    '{cls: 2'b10, func: 6'd2, exp_v: 2'b10},
    '{cls: 2'b00, func: 6'd3, exp_v: 2'b01},
    '{cls: 2'b11, func: 6'd4, exp_v: 2'b01},
    '{cls: 2'b01, func: 6'd5, exp_v: 2'b01},
    '{cls: 2'b10, func: 6'd6, exp_v: 2'b10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = '0; disp_cls = '0; disp_func = '0; disp_imm = '0;
    disp_dst = '0; disp_src = '0; disp_srdy = '0; disp_bmask = '0;
    wb_valid = '0; wb_tag = '0;
    mp_valid = 1'b0; mp_mask = '0; res_valid = 1'b0; res_mask = '0;
  endtask

  task automatic put(input int d, input logic [1:0] cls, input logic [5:0] f,
                     input logic [15:0] imm, input logic [5:0] dst,
                     input logic [17:0] src, input logic [2:0] rdy, input logic [3:0] bm);
    disp_valid[d]          = 1'b1;
    disp_cls[d*2 +: 2]     = cls;
    disp_func[d*6 +: 6]    = f;
    disp_imm[d*16 +: 16]   = imm;
    disp_dst[d*6 +: 6]     = dst;
    disp_src[d*18 +: 18]   = src;
    disp_srdy[d*3 +: 3]    = rdy;
    disp_bmask[d*4 +: 4]   = bm;
  endtask

  task automatic wb(input int p, input logic [5:0] t);
    wb_valid[p]       = 1'b1;
    wb_tag[p*6 +: 6]  = t;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    idle();
    repeat (3) nxt();
    check("R1 iss_valid in reset", 32'(iss_valid), 0);
    rst = 1'b0;
    nxt();
    check("R1 iss_valid after reset", 32'(iss_valid), 0);
    check("R1 full after reset", 32'(full), 0);

    // table walk: class steering, forwarding, single issue
    foreach (VEC[v]) begin
      idle();
      put(0, VEC[v].cls, VEC[v].func, 16'hA000 + 16'(v), 6'(v + 8),
          {6'd3, 6'd2, 6'd1}, 3'b111, 4'b0000);
      nxt(); idle(); nxt();
      check("R3 steering port", 32'(iss_valid), 32'(VEC[v].exp_v));
      if (VEC[v].exp_v == 2'b01) begin
        check("R9 func port0", 32'(iss_func[5:0]), 32'(VEC[v].func));
        check("R9 imm port0", 32'(iss_imm[15:0]), 32'hA000 + 32'(v));
        check("R9 dst port0", 32'(iss_dst[5:0]), 32'(v + 8));
        check("R9 src port0", 32'(iss_src[17:0]), 32'({6'd3, 6'd2, 6'd1}));
      end else begin
        check("R9 func port1", 32'(iss_func[11:6]), 32'(VEC[v].func));
        check("R9 src port1", 32'(iss_src[35:18]), 32'({6'd3, 6'd2, 6'd1}));
      end
      nxt();
      check("R4 issues once", 32'(iss_valid), 0);
    end

    // R6 wake-up through write-back port 2; R4 waits for all sources
    idle(); put(0, 2'b00, 6'd10, 16'h0, 6'd0, {6'd0, 6'd12, 6'd0}, 3'b101, 4'b0);
    nxt(); idle(); nxt();
    check("R4 not ready holds", 32'(iss_valid), 0);
    wb(2, 6'd12); nxt(); idle(); nxt();
    check("R6 woken issue", 32'(iss_valid), 1);
    check("R6 woken func", 32'(iss_func[5:0]), 10);

    // R5 same-cycle bypass at dispatch
    idle(); put(0, 2'b00, 6'd11, 16'h0, 6'd0, {6'd20, 6'd0, 6'd0}, 3'b011, 4'b0);
    wb(0, 6'd20);
    nxt(); idle(); nxt();
    check("R5 bypass issue", 32'(iss_valid), 1);
    check("R5 bypass func", 32'(iss_func[5:0]), 11);

    // R7 oldest first even when it sits at a higher index
    idle();
    put(0, 2'b01, 6'd21, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0);
    put(1, 2'b01, 6'd22, 16'h0, 6'd0, {12'd0, 6'd30}, 3'b110, 4'b0);
    nxt(); idle(); nxt();
    check("R7 first ready", 32'(iss_func[5:0]), 21);
    put(0, 2'b01, 6'd23, 16'h0, 6'd0, {12'd0, 6'd30}, 3'b110, 4'b0);
    nxt(); idle(); wb(1, 6'd30); nxt(); idle(); nxt();
    check("R7 older wins", 32'(iss_func[5:0]), 22);
    nxt();
    check("R7 younger next", 32'(iss_func[5:0]), 23);
    check("R7 younger valid", 32'(iss_valid), 1);

    // R8 pairing of either-class entries
    idle();
    put(0, 2'b00, 6'd40, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0);
    put(1, 2'b00, 6'd41, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0);
    nxt(); idle(); nxt();
    check("R8 two any valid", 32'(iss_valid), 3);
    check("R8 two any funcs", 32'(iss_func), 32'({6'd41, 6'd40}));
    put(0, 2'b01, 6'd42, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0);
    put(1, 2'b00, 6'd43, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0);
    nxt(); idle(); nxt();
    check("R8 any to port1", 32'(iss_func), 32'({6'd43, 6'd42}));
    put(0, 2'b10, 6'd44, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0);
    put(1, 2'b00, 6'd45, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0);
    nxt(); idle(); nxt();
    check("R8 any to port0", 32'(iss_func), 32'({6'd44, 6'd45}));

    // R10 mispredict flush of held entries
    idle();
    put(0, 2'b00, 6'd50, 16'h0, 6'd0, {12'd0, 6'd40}, 3'b110, 4'b0010);
    put(1, 2'b00, 6'd51, 16'h0, 6'd0, {12'd0, 6'd40}, 3'b110, 4'b0001);
    nxt(); idle(); mp_valid = 1'b1; mp_mask = 4'b0010;
    nxt(); idle(); wb(0, 6'd40); nxt(); idle(); nxt();
    check("R10 survivor only", 32'(iss_valid), 1);
    check("R10 survivor func", 32'(iss_func[5:0]), 51);
    nxt();
    check("R10 flushed silent", 32'(iss_valid), 0);

    // R10 same-cycle dispatch with overlapping mask is dropped
    idle(); put(0, 2'b00, 6'd52, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0100);
    mp_valid = 1'b1; mp_mask = 4'b0100;
    nxt(); idle(); nxt();
    check("R10 dispatch dropped", 32'(iss_valid), 0);

    // R11 resolve protects from a later mispredict on that bit
    idle(); put(0, 2'b00, 6'd60, 16'h0, 6'd0, {12'd0, 6'd41}, 3'b110, 4'b1000);
    nxt(); idle(); res_valid = 1'b1; res_mask = 4'b1000;
    nxt(); idle(); mp_valid = 1'b1; mp_mask = 4'b1000;
    nxt(); idle(); wb(0, 6'd41); nxt(); idle(); nxt();
    check("R11 kept entry", 32'(iss_valid), 1);
    check("R11 kept func", 32'(iss_func[5:0]), 60);

    // R2 full threshold and ignored dispatch
    for (int c = 0; c < 3; c++) begin
      idle();
      for (int d = 0; d < 4; d++)
        put(d, 2'b00, 6'd55, 16'h0, 6'd0, {12'd0, 6'd50}, 3'b110, 4'b0);
      nxt();
    end
    idle();
    check("R2 four free not full", 32'(full), 0);
    put(0, 2'b00, 6'd55, 16'h0, 6'd0, {12'd0, 6'd50}, 3'b110, 4'b0);
    nxt(); idle();
    check("R2 three free full", 32'(full), 1);
    for (int d = 0; d < 4; d++)
      put(d, 2'b00, 6'd56, 16'h0, 6'd0, 18'd0, 3'b111, 4'b0);
    nxt(); idle();
    check("R2 still full", 32'(full), 1);
    wb(2, 6'd50);
    nxt(); idle();
    cnt = 0;
    for (int c = 0; c < 10; c++) begin
      nxt();
      cnt += int'(iss_valid[0]) + int'(iss_valid[1]);
    end
    check("R2 full dispatch ignored", 32'(cnt), 13);
    check("R2 drained not full", 32'(full), 0);

    // R1 reset mid-run empties the queue
    idle(); put(0, 2'b00, 6'd61, 16'h0, 6'd0, {12'd0, 6'd55}, 3'b110, 4'b0);
    nxt(); idle(); rst = 1'b1; nxt(); nxt(); rst = 1'b0;
    wb(0, 6'd55); nxt(); idle(); nxt();
    check("R1 reset cleared entries", 32'(iss_valid), 0);
    check("R1 reset full", 32'(full), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule